// File: doc/BRIEF.md
# Flash Program and Erase Step Sequencer

This block sits between a host and the control pins of an on-chip nonvolatile byte array. It walks the array's high-voltage enables through a fixed order of steps for two operations, erasing the whole array and programming one row. Each step is held for a minimum dwell set by a down-counter. The counter is loaded from a microsecond figure scaled by the `CLK_HZ` parameter and rounded up. Before it starts anything, the block checks three things: the protect value, row alignment and the erased state of each target byte.

The host issues commands on a valid/ready channel. `cmd_ready` is high only in the idle state and, during row programming, while the block waits for the next byte. A host that has a command to send holds `cmd_valid` until it sees `cmd_ready`. A command presented while `cmd_ready` is low is dropped and flagged: the block treats it as a busy-time command. A separate combinational read port returns array data while the block is idle, and 0xFF at all other times.

Top module: `flash_seq_ctrl`

## Requirements
- R1: A row is 32 bytes starting at an address with its low five bits zero. A row-program start latches the row of `cmd_addr`. A byte write whose address is outside that row sets `err`, leaves the array unchanged and ends the operation through the normal shutdown steps.
- R2: A byte is programmed only if the array reads 0xFF at that address. Any other value sets `err`, writes nothing and ends the operation.
- R3: A mass-erase command while `prot_val` is not 0xFF sets `err`, leaves `busy` low and asserts no array enable.
- R4: Mass erase performs these steps in order. First it raises erase and mass together with a setup write. After at least 10 us it raises the high-voltage enable. After at least 4 ms it drops erase and mass. After at least 100 us it drops the high-voltage enable. After at least 1 us of recovery it sets `done` and returns to idle.
- R5: Row programming performs these steps in order. First it raises the program enable with a setup write to the latched address. After at least 10 us it raises the high-voltage enable. It accepts no byte for at least 5 us after that. After each byte written it waits at least 30 us before `cmd_ready` returns.
- R6: Finishing a row, by command or after an error, first drops the program enable. After at least 5 us it drops the high-voltage enable. After at least 1 us it sets `done`. `busy` never falls while any enable is high.
- R7: After a mass erase, every array byte reads 0xFF.
- R8: The high-voltage enable rises only while exactly one of program or erase is high, and program and erase are never high together.
- R9: A command presented while `cmd_ready` is low is ignored. It sets `err`, and the operation in progress continues unchanged.
- R10: `rd_data` shows the array byte at `rd_addr` only while `busy` is low. While `busy` is high it reads 0xFF.
- R11: After reset, `busy`, `done`, `err` and all array enables are low, and `cmd_ready` is high.
- R12: The `cmd_op` encoding is: 0 erases the whole array, 1 starts a row, 2 writes a byte, 3 ends a row. A byte write or a row end received in idle sets `err`. An accepted start clears `done` and `err`. `done` and `err` hold their value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 2 | Command code (R12) |
| cmd_addr | input | AW | Command address |
| cmd_data | input | 8 | Byte to program |
| prot_val | input | 8 | Block-protect value; 0xFF means unprotected |
| rd_addr | input | AW | Host read address |
| rd_data | output | 8 | Host read data (0xFF while busy) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation completed its sequence |
| err | output | 1 | Last operation or command was rejected |
| arr_erase | output | 1 | Array erase enable |
| arr_mass | output | 1 | Array whole-array select |
| arr_pgm | output | 1 | Array program enable |
| arr_hven | output | 1 | Array high-voltage enable |
| arr_we | output | 1 | Array write strobe (setup or data) |
| arr_addr | output | AW | Array address |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data at `arr_addr` |

## Verification
Most internal faults here show up as timing or as bad enable combinations. A sequencer stuck in the wrong step, or a dwell counter loaded with the wrong value, moves an enable edge by a countable number of cycles. That shifted edge is visible the first time the affected step runs, so the bench counts cycles between enable edges. A bad row or erased-state decision appears at the end of that same operation, as a wrong `err` or a wrong readback byte. An enable combination outside the allowed set is flagged in the cycle it occurs.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_ERASE_ALL = 2'd0,
    OP_ROW_START = 2'd1,
    OP_BYTE_WR   = 2'd2,
    OP_ROW_END   = 2'd3
  } cmd_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_E_SETUP, S_E_NVS, S_E_HOLD, S_E_NVH,
    S_P_SETUP, S_P_NVS, S_P_PGS, S_P_WAIT, S_P_CHK, S_P_PROG,
    S_P_NVH, S_RCV
  } seq_state_e;

  // Minimum dwell figures in microseconds
  localparam longint unsigned T_NVS_US   = 10;
  localparam longint unsigned T_PGS_US   = 5;
  localparam longint unsigned T_PROG_US  = 30;
  localparam longint unsigned T_NVH_US   = 100;
  localparam longint unsigned T_ERASE_US = 4000;
  localparam longint unsigned T_RCV_US   = 1;

  // Cycles covering a time, rounded up, never less than one
  function automatic longint unsigned dwell_cycles(longint unsigned hz,
                                                   longint unsigned us);
    longint unsigned c;
    c = (us * hz + 64'd999999) / 64'd1000000;
    return (c == 0) ? 64'd1 : c;
  endfunction

endpackage

// File: rtl/flash_dwell_timer.sv
module flash_dwell_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/flash_access_guard.sv
module flash_access_guard #(
  parameter int AW = 16,
  parameter int RB = 5
) (
  input  logic [AW-1:0]  cmd_addr,
  input  logic [AW-RB-1:0] row_q,
  input  logic [7:0]     arr_rdata,
  input  logic [7:0]     prot_val,
  output logic           in_row,
  output logic           byte_blank,
  output logic           unprotected
);
  assign in_row      = (cmd_addr[AW-1:RB] == row_q);
  assign byte_blank  = (arr_rdata == 8'hFF);
  assign unprotected = (prot_val == 8'hFF);
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl #(
  parameter int unsigned CLK_HZ    = 8_000_000,
  parameter int          AW        = 16,
  parameter int          ROW_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_data,
  input  logic [7:0]    prot_val,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          arr_erase,
  output logic          arr_mass,
  output logic          arr_pgm,
  output logic          arr_hven,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [7:0]    arr_wdata,
  input  logic [7:0]    arr_rdata
);
  import flash_seq_pkg::*;

  localparam int RB = $clog2(ROW_BYTES);
  localparam longint unsigned NVS_L   = dwell_cycles(CLK_HZ, T_NVS_US);
  localparam longint unsigned PGS_L   = dwell_cycles(CLK_HZ, T_PGS_US);
  localparam longint unsigned PROG_L  = dwell_cycles(CLK_HZ, T_PROG_US);
  localparam longint unsigned NVH_L   = dwell_cycles(CLK_HZ, T_NVH_US);
  localparam longint unsigned ERASE_L = dwell_cycles(CLK_HZ, T_ERASE_US);
  localparam longint unsigned RCV_L   = dwell_cycles(CLK_HZ, T_RCV_US);
  localparam int CW = $clog2(ERASE_L + 1);
  localparam logic [CW-1:0] NVS_C   = CW'(NVS_L);
  localparam logic [CW-1:0] PGS_C   = CW'(PGS_L);
  localparam logic [CW-1:0] PROG_C  = CW'(PROG_L);
  localparam logic [CW-1:0] NVH_C   = CW'(NVH_L);
  localparam logic [CW-1:0] ERASE_C = CW'(ERASE_L);
  localparam logic [CW-1:0] RCV_C   = CW'(RCV_L);

  seq_state_e state_q, state_n;
  logic erase_q, erase_n, pgm_q, pgm_n, hven_q, hven_n;
  logic done_q, done_n, err_q, err_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [7:0] data_q, data_n;
  logic [AW-RB-1:0] row_q, row_n;
  logic tmr_load, tmr_expired, we_c, accept;
  logic [CW-1:0] tmr_val;
  logic in_row, byte_blank, unprotected;

  flash_dwell_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  flash_access_guard #(.AW(AW), .RB(RB)) u_guard (
    .cmd_addr(cmd_addr), .row_q(row_q), .arr_rdata(arr_rdata),
    .prot_val(prot_val), .in_row(in_row), .byte_blank(byte_blank),
    .unprotected(unprotected)
  );

  assign cmd_ready = (state_q == S_IDLE) || (state_q == S_P_WAIT);
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    state_n = state_q;
    erase_n = erase_q;
    pgm_n   = pgm_q;
    hven_n  = hven_q;
    done_n  = done_q;
    err_n   = err_q;
    addr_n  = addr_q;
    data_n  = data_q;
    row_n   = row_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    we_c     = 1'b0;
    if (cmd_valid && !cmd_ready) err_n = 1'b1;
    unique case (state_q)
      S_IDLE: if (accept) begin
        unique case (cmd_op_e'(cmd_op))
          OP_ERASE_ALL: begin
            done_n = 1'b0;
            if (!unprotected) err_n = 1'b1;
            else begin
              err_n   = 1'b0;
              erase_n = 1'b1;
              addr_n  = cmd_addr;
              state_n = S_E_SETUP;
            end
          end
          OP_ROW_START: begin
            done_n  = 1'b0;
            err_n   = 1'b0;
            pgm_n   = 1'b1;
            addr_n  = cmd_addr;
            row_n   = cmd_addr[AW-1:RB];
            state_n = S_P_SETUP;
          end
          default: err_n = 1'b1;
        endcase
      end
      S_E_SETUP: begin
        we_c = 1'b1; tmr_load = 1'b1; tmr_val = NVS_C; state_n = S_E_NVS;
      end
      S_E_NVS: if (tmr_expired) begin
        hven_n = 1'b1; tmr_load = 1'b1; tmr_val = ERASE_C; state_n = S_E_HOLD;
      end
      S_E_HOLD: if (tmr_expired) begin
        erase_n = 1'b0; tmr_load = 1'b1; tmr_val = NVH_C; state_n = S_E_NVH;
      end
      S_E_NVH: if (tmr_expired) begin
        hven_n = 1'b0; tmr_load = 1'b1; tmr_val = RCV_C; state_n = S_RCV;
      end
      S_P_SETUP: begin
        we_c = 1'b1; tmr_load = 1'b1; tmr_val = NVS_C; state_n = S_P_NVS;
      end
      S_P_NVS: if (tmr_expired) begin
        hven_n = 1'b1; tmr_load = 1'b1; tmr_val = PGS_C; state_n = S_P_PGS;
      end
      S_P_PGS: if (tmr_expired) state_n = S_P_WAIT;
      S_P_WAIT: if (accept) begin
        unique case (cmd_op_e'(cmd_op))
          OP_BYTE_WR: begin
            if (in_row) begin
              addr_n  = cmd_addr;
              data_n  = cmd_data;
              state_n = S_P_CHK;
            end else begin
              err_n = 1'b1; pgm_n = 1'b0;
              tmr_load = 1'b1; tmr_val = PGS_C; state_n = S_P_NVH;
            end
          end
          OP_ROW_END: begin
            pgm_n = 1'b0; tmr_load = 1'b1; tmr_val = PGS_C; state_n = S_P_NVH;
          end
          default: err_n = 1'b1;
        endcase
      end
      S_P_CHK: begin
        if (byte_blank) begin
          we_c = 1'b1; tmr_load = 1'b1; tmr_val = PROG_C; state_n = S_P_PROG;
        end else begin
          err_n = 1'b1; pgm_n = 1'b0;
          tmr_load = 1'b1; tmr_val = PGS_C; state_n = S_P_NVH;
        end
      end
      S_P_PROG: if (tmr_expired) state_n = S_P_WAIT;
      S_P_NVH: if (tmr_expired) begin
        hven_n = 1'b0; tmr_load = 1'b1; tmr_val = RCV_C; state_n = S_RCV;
      end
      S_RCV: if (tmr_expired) begin
        done_n = 1'b1; state_n = S_IDLE;
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      erase_q <= 1'b0;
      pgm_q   <= 1'b0;
      hven_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= 8'hFF;
      row_q   <= '0;
    end else begin
      state_q <= state_n;
      erase_q <= erase_n;
      pgm_q   <= pgm_n;
      hven_q  <= hven_n;
      done_q  <= done_n;
      err_q   <= err_n;
      addr_q  <= addr_n;
      data_q  <= data_n;
      row_q   <= row_n;
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign arr_erase = erase_q;
  assign arr_mass  = erase_q;
  assign arr_pgm   = pgm_q;
  assign arr_hven  = hven_q;
  assign arr_we    = we_c;
  assign arr_addr  = (state_q == S_IDLE) ? rd_addr : addr_q;
  assign arr_wdata = data_q;
  assign rd_data   = (state_q == S_IDLE) ? arr_rdata : 8'hFF;
endmodule

// File: rtl/flash_seq_checker.sv
module flash_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       busy,
  input logic       err,
  input logic       arr_erase,
  input logic       arr_pgm,
  input logic       arr_hven,
  input logic       arr_we,
  input logic [7:0] rd_data
);
  a_r8_hven_rise_single_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_hven) |-> (arr_erase ^ arr_pgm));

  a_r8_never_both_modes: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_erase && arr_pgm));

  a_r5_hv_write_is_program: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && arr_hven) |-> (arr_pgm && !arr_erase));

  a_r9_late_cmd_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> err);

  a_r10_blank_read_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_data == 8'hFF));

  a_r6_quiet_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!arr_hven && !arr_pgm && !arr_erase));
endmodule

bind flash_seq_ctrl flash_seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .busy(busy), .err(err), .arr_erase(arr_erase), .arr_pgm(arr_pgm),
  .arr_hven(arr_hven), .arr_we(arr_we), .rd_data(rd_data)
);

// File: tb/flash_seq_ctrl_bench.sv
module flash_seq_ctrl_bench;
  localparam int AW = 10;
  localparam int unsigned HZ = 1_000_000;
  localparam int NVS = 10, PGS = 5, PROG = 30, NVH = 100, ERS = 4000, RCV = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [AW-1:0] cmd_addr = '0, rd_addr = '0, arr_addr;
  logic [7:0] cmd_data = 8'h00, prot_val = 8'hFF, rd_data, arr_wdata, arr_rdata;
  logic busy, done, err, arr_erase, arr_mass, arr_pgm, arr_hven, arr_we;

  int checks = 0, fails = 0;
  logic [7:0] mem [0:(1<<AW)-1];

  always #10 clk = ~clk;

  flash_seq_ctrl #(.CLK_HZ(HZ), .AW(AW), .ROW_BYTES(32)) u_flash_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .prot_val(prot_val), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .done(done), .err(err), .arr_erase(arr_erase), .arr_mass(arr_mass),
    .arr_pgm(arr_pgm), .arr_hven(arr_hven), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
  );

  // Byte-array model: programming clears bits, erase sets all bytes
  assign arr_rdata = mem[arr_addr];
  initial for (int i = 0; i < (1<<AW); i++) mem[i] = 8'hFF;
  always @(posedge clk) begin
    if (arr_hven && arr_erase && arr_mass)
      for (int i = 0; i < (1<<AW); i++) mem[i] <= 8'hFF;
    else if (arr_we && arr_hven && arr_pgm)
      mem[arr_addr] <= mem[arr_addr] & arr_wdata;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_ge(string req, int act, int minv);
    checks++;
    if (act < minv) begin
      fails++;
      $display("FAIL %s actual=%0d expected>=%0d", req, act, minv);
    end
  endtask

  function automatic logic sig_of(int sel);
    case (sel)
      0: return arr_hven;
      1: return arr_erase;
      2: return arr_pgm;
      3: return cmd_ready;
      default: return busy;
    endcase
  endfunction

  // Counts falling edges until the selected signal reaches val
  task automatic measure(int sel, logic val, output int n);
    n = 0;
    while (sig_of(sel) !== val && n < 20000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic pulse_cmd(logic [1:0] op, logic [AW-1:0] a, logic [7:0] d);
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send_cmd(logic [1:0] op, logic [AW-1:0] a, logic [7:0] d);
    int n;
    measure(3, 1'b1, n);
    pulse_cmd(op, a, d);
  endtask

  task automatic wait_idle();
    int n;
    @(negedge clk);
    measure(4, 1'b0, n);
  endtask

  task automatic read_chk(string req, logic [AW-1:0] a, logic [7:0] exp);
    rd_addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  // start, write address, data, expect error, expect readback
  localparam logic [36:0] VEC [0:4] = '{
    {10'h040, 10'h041, 8'hA5, 1'b0, 8'hA5},
    {10'h040, 10'h041, 8'h00, 1'b1, 8'hA5},
    {10'h060, 10'h080, 8'h12, 1'b1, 8'hFF},
    {10'h3E0, 10'h3FF, 8'h3C, 1'b0, 8'h3C},
    {10'h000, 10'h01F, 8'h7E, 1'b0, 8'h7E}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    int n, m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy, 0);
    chk("R11 ready", cmd_ready, 1);
    chk("R11 enables", {arr_erase, arr_mass, arr_pgm, arr_hven}, 0);
    chk("R11 done/err", {done, err}, 0);
    read_chk("R10 idle read", 10'h041, 8'hFF);

    // R12 byte write in idle is an error
    send_cmd(2'd2, 10'h041, 8'h11);
    chk("R12 idle byte err", err, 1);
    chk("R12 idle busy", busy, 0);
    read_chk("R12 no write", 10'h041, 8'hFF);

    // Vector table: R1, R2
    for (int v = 0; v < 5; v++) begin
      send_cmd(2'd1, VEC[v][36:27], 8'h00);
      send_cmd(2'd2, VEC[v][26:17], VEC[v][16:9]);
      if (!VEC[v][8]) send_cmd(2'd3, 10'h000, 8'h00);
      wait_idle();
      chk($sformatf("R1/R2 vec%0d err", v), err, VEC[v][8]);
      chk($sformatf("R6 vec%0d done", v), done, 1);
      read_chk($sformatf("R1/R2 vec%0d data", v), VEC[v][26:17], VEC[v][7:0]);
    end

    // R5/R6/R10 timed two-byte row
    send_cmd(2'd1, 10'h100, 8'h00);
    chk("R5 pgm first", {arr_pgm, arr_hven}, 2'b10);
    read_chk("R10 busy read", 10'h041, 8'hFF);
    measure(0, 1'b1, n);
    chk_ge("R5 nvs", n, NVS);
    chk("R8 one mode at hv", arr_pgm ^ arr_erase, 1);
    measure(3, 1'b1, n);
    chk_ge("R5 pgs", n, PGS);
    pulse_cmd(2'd2, 10'h105, 8'h5A);
    measure(3, 1'b1, n);
    chk_ge("R5 prog", n + 1, PROG);
    send_cmd(2'd2, 10'h106, 8'hC3);
    send_cmd(2'd3, 10'h000, 8'h00);
    chk("R6 pgm off", arr_pgm, 0);
    measure(0, 1'b0, n);
    chk_ge("R6 pgm-hv gap", n, PGS);
    measure(4, 1'b0, n);
    chk_ge("R6 recovery", n, RCV);
    chk("R6 done", {done, err}, 2'b10);
    read_chk("R5 byte a", 10'h105, 8'h5A);
    read_chk("R5 byte b", 10'h106, 8'hC3);

    // R3 protected erase refused
    prot_val = 8'h7F;
    send_cmd(2'd0, 10'h000, 8'h00);
    @(negedge clk);
    chk("R3 err", err, 1);
    chk("R3 quiet", {busy, arr_erase, arr_mass, arr_hven}, 0);
    read_chk("R3 data kept", 10'h041, 8'hA5);
    prot_val = 8'hFF;

    // R4/R7/R9 mass erase
    send_cmd(2'd0, 10'h123, 8'h00);
    chk("R4 erase+mass", {arr_erase, arr_mass, arr_hven, err}, 4'b1100);
    measure(0, 1'b1, n);
    chk_ge("R4 nvs", n, NVS);
    chk("R8 one mode at hv", arr_pgm ^ arr_erase, 1);
    measure(1, 1'b0, n);
    chk_ge("R4 hold", n, ERS);
    pulse_cmd(2'd1, 10'h200, 8'h00);
    chk("R9 flagged", err, 1);
    chk("R9 ignored", {arr_pgm, arr_hven}, 2'b01);
    measure(0, 1'b0, m);
    chk_ge("R4 nvh", m + 1, NVH);
    measure(4, 1'b0, n);
    chk_ge("R4 recovery", n, RCV);
    chk("R4 done", done, 1);
    chk("R9 no program", arr_pgm, 0);
    read_chk("R7 blank a", 10'h041, 8'hFF);
    read_chk("R7 blank b", 10'h3FF, 8'hFF);
    read_chk("R7 blank c", 10'h105, 8'hFF);

    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule